// File: doc/BRIEF.md
# DDR SDRAM Command Timing Checker

This block watches the command bus of a four-bank DDR SDRAM and reports protocol misuse. On every rising clock edge it samples the chip select, the three command strobes, the bank address and the A10 line. It decodes the command, tracks whether each bank is idle, open or closing under auto-precharge, and measures the cycle distance between related commands. Any command that breaks a sequencing rule or a minimum spacing raises a violation code.

The checker never drives the bus. It is placed beside a memory controller in simulation or in a debug build. Each command is reported one cycle after it is sampled, as a decoded command code and a violation code. A sticky mask collects every rule broken since reset. All spacings are parameters in clock cycles. The defaults assume a 7.5 ns clock and a burst length of 4.

Top module: `ddr_cmd_checker`

## Requirements
- R1: The pins {cs_n, ras_n, cas_n, we_n} decode as 0000 mode-set (code 1), 0001 refresh (2), 0011 activate (3), 0101 read (4), 0100 write (5), 0110 burst stop (6), 0010 precharge (7) and 0111 no-operation (0). Any pattern with cs_n high is deselect (8). The code appears on cmd_o one cycle after the command is sampled.
- R2: ba = 0..3 selects bank 0..3. An activate opens the selected bank. A precharge closes the selected bank, or every open bank when a10 is high, and then ba is ignored. bank_state_o[2i+1:2i] shows bank i as 0 idle, 1 open or 2 closing, updated in the same cycle as cmd_o.
- R3: A read or write to an idle bank gives code 3 and leaves that bank idle.
- R4: A read or write sent fewer than T_RCD (3) cycles after an activate to the same bank gives code 4.
- R5: An activate to a bank that is already open gives code 5.
- R6: Two activates to the same bank fewer than T_RC (9) cycles apart give code 6.
- R7: An activate sent fewer than T_RRD (2) cycles after an activate to a different bank gives code 7.
- R8: An activate to an idle bank fewer than T_RP (3) cycles after that bank closed gives code 8. So does an activate to a closing bank.
- R9: A precharge that closes a bank fewer than T_RAS (6) cycles after its activate gives code 9.
- R10: A precharge that closes a bank fewer than BURST_LEN/2 + T_WR (4) cycles after a write to that bank gives code 10.
- R11: A read or write with a10 high puts its bank into the closing state. The bank counts as closed BURST_LEN/2 cycles after that command. A read or write to a closing bank gives code 11.
- R12: A mode-set while any bank is not idle gives code 1. Any command other than no-operation or deselect sent fewer than T_MRD (2) cycles after a mode-set gives code 2.
- R13: After reset all outputs are zero. viol_code_o shows, one cycle after the command, the lowest-numbered rule that command broke (0 if none). viol_sticky_o bit k sets when code k is reported and stays set until reset. Bit 0 stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge samples |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | All-bank precharge / auto-precharge select |
| cmd_o | output | 4 | Decoded command code |
| bank_state_o | output | 2*2^BA_W | Two-bit state per bank |
| viol_code_o | output | 4 | Violation code of the previous command |
| viol_sticky_o | output | 12 | Accumulated violation mask |

## Verification
The properties assume that every command pin and a10 hold known levels at each sampled edge after reset, and that only one command is presented per cycle. They also assume that nothing but reset clears the sticky mask. The stimulus holds reset low for several cycles from time zero with the bus at no-operation. It then changes the pins only on falling clock edges and draws every value from a fixed set of legal pin patterns, so no unknown or half-changed level is ever sampled.

// File: rtl/ddrchk_pkg.sv
package ddrchk_pkg;

    typedef enum logic [3:0] {
        CMD_NOP = 4'd0,
        CMD_MRS = 4'd1,
        CMD_REF = 4'd2,
        CMD_ACT = 4'd3,
        CMD_RD  = 4'd4,
        CMD_WR  = 4'd5,
        CMD_BST = 4'd6,
        CMD_PRE = 4'd7,
        CMD_DES = 4'd8
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPEN    = 2'd1,
        BK_CLOSING = 2'd2
    } bank_st_e;

    localparam int NUM_CODES   = 12;
    localparam int V_MRS_BUSY  = 1;
    localparam int V_MRS_GAP   = 2;
    localparam int V_COL_IDLE  = 3;
    localparam int V_RCD       = 4;
    localparam int V_ACT_OPEN  = 5;
    localparam int V_RC        = 6;
    localparam int V_RRD       = 7;
    localparam int V_RP        = 8;
    localparam int V_RAS       = 9;
    localparam int V_WR        = 10;
    localparam int V_AP_BUSY   = 11;

    typedef struct packed {
        cmd_e                   cmd;
        logic [3:0]             code;
        logic [NUM_CODES-1:0]   sticky;
    } report_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddrchk_decode.sv
module ddrchk_decode
    import ddrchk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        if (cs_n) begin
            cmd = CMD_DES;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b000:  cmd = CMD_MRS;
                3'b001:  cmd = CMD_REF;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b110:  cmd = CMD_BST;
                3'b010:  cmd = CMD_PRE;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/ddrchk_bank.sv
module ddrchk_bank
    import ddrchk_pkg::*;
#(
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RAS     = 6,
    parameter int T_RC      = 9,
    parameter int T_WR      = 2,
    parameter int BURST_LEN = 4,
    parameter int LIM       = 9,
    parameter int CNT_W     = 4
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  cmd_e                 cmd,
    input  logic                 sel,
    input  logic                 a10,
    output bank_st_e             st_o,
    output logic [NUM_CODES-1:0] req_o
);

    localparam int BEATS_CYC = BURST_LEN / 2;
    localparam int WR_GAP    = BEATS_CYC + T_WR;
    localparam logic [CNT_W-1:0] SAT = CNT_W'(LIM);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        bank_st_e           st;
        logic [CNT_W-1:0]   act;
        logic [CNT_W-1:0]   pre;
        logic [CNT_W-1:0]   wr;
        logic [CNT_W-1:0]   ap;
    } bank_t;

    bank_t s_d, s_q;
    logic [NUM_CODES-1:0] req_d;

    always_comb begin
        s_d   = s_q;
        req_d = '0;

        if (s_q.act != SAT) s_d.act = s_q.act + ONE;
        if (s_q.pre != SAT) s_d.pre = s_q.pre + ONE;
        if (s_q.wr  != SAT) s_d.wr  = s_q.wr  + ONE;

        // auto-precharge countdown: last burst cycle closes the bank
        if (s_q.st == BK_CLOSING) begin
            if (s_q.ap <= ONE) begin
                s_d.st  = BK_IDLE;
                s_d.pre = ONE;
                s_d.ap  = '0;
            end else begin
                s_d.ap  = s_q.ap - ONE;
            end
        end

        if (sel) begin
            unique case (cmd)
                CMD_ACT: begin
                    if (s_q.st == BK_OPEN)    req_d[V_ACT_OPEN] = 1'b1;
                    if (s_q.st == BK_CLOSING) req_d[V_RP]       = 1'b1;
                    if (s_q.st == BK_IDLE) begin
                        if (s_q.act < CNT_W'(T_RC)) req_d[V_RC] = 1'b1;
                        if (s_q.pre < CNT_W'(T_RP)) req_d[V_RP] = 1'b1;
                    end
                    s_d.st  = BK_OPEN;
                    s_d.act = ONE;
                    s_d.ap  = '0;
                end
                CMD_RD, CMD_WR: begin
                    if (s_q.st == BK_IDLE)    req_d[V_COL_IDLE] = 1'b1;
                    if (s_q.st == BK_CLOSING) req_d[V_AP_BUSY]  = 1'b1;
                    if (s_q.st == BK_OPEN) begin
                        if (s_q.act < CNT_W'(T_RCD)) req_d[V_RCD] = 1'b1;
                        if (cmd == CMD_WR) s_d.wr = ONE;
                        if (a10) begin
                            s_d.st = BK_CLOSING;
                            s_d.ap = CNT_W'(BEATS_CYC);
                        end
                    end
                end
                CMD_PRE: begin
                    if (s_q.st == BK_OPEN) begin
                        if (s_q.act < CNT_W'(T_RAS))  req_d[V_RAS] = 1'b1;
                        if (s_q.wr  < CNT_W'(WR_GAP)) req_d[V_WR]  = 1'b1;
                        s_d.st  = BK_IDLE;
                        s_d.pre = ONE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st  <= BK_IDLE;
            s_q.act <= SAT;
            s_q.pre <= SAT;
            s_q.wr  <= SAT;
            s_q.ap  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign st_o  = s_q.st;
    assign req_o = req_d;

endmodule

// File: rtl/ddrchk_global.sv
module ddrchk_global
    import ddrchk_pkg::*;
#(
    parameter int T_RRD = 2,
    parameter int T_MRD = 2,
    parameter int BA_W  = 2,
    parameter int LIM   = 9,
    parameter int CNT_W = 4
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  cmd_e                 cmd,
    input  logic [BA_W-1:0]      ba,
    input  logic                 any_busy,
    output logic [NUM_CODES-1:0] req_o
);

    localparam logic [CNT_W-1:0] SAT = CNT_W'(LIM);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] mrs;
        logic [CNT_W-1:0] act;
        logic [BA_W-1:0]  last_ba;
    } glob_t;

    glob_t g_d, g_q;
    logic [NUM_CODES-1:0] req_d;

    always_comb begin
        g_d   = g_q;
        req_d = '0;

        if (g_q.mrs != SAT) g_d.mrs = g_q.mrs + ONE;
        if (g_q.act != SAT) g_d.act = g_q.act + ONE;

        if (cmd != CMD_NOP && cmd != CMD_DES && g_q.mrs < CNT_W'(T_MRD))
            req_d[V_MRS_GAP] = 1'b1;

        if (cmd == CMD_MRS) begin
            if (any_busy) req_d[V_MRS_BUSY] = 1'b1;
            g_d.mrs = ONE;
        end

        if (cmd == CMD_ACT) begin
            if (ba != g_q.last_ba && g_q.act < CNT_W'(T_RRD))
                req_d[V_RRD] = 1'b1;
            g_d.act     = ONE;
            g_d.last_ba = ba;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q.mrs     <= SAT;
            g_q.act     <= SAT;
            g_q.last_ba <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign req_o = req_d;

endmodule

// File: rtl/ddr_cmd_checker.sv
module ddr_cmd_checker
    import ddrchk_pkg::*;
#(
    parameter int BA_W      = 2,
    parameter int BURST_LEN = 4,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RRD     = 2,
    parameter int T_RC      = 9,
    parameter int T_RAS     = 6,
    parameter int T_WR      = 2,
    parameter int T_MRD     = 2
)(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cs_n,
    input  logic                          ras_n,
    input  logic                          cas_n,
    input  logic                          we_n,
    input  logic [BA_W-1:0]               ba,
    input  logic                          a10,
    output logic [3:0]                    cmd_o,
    output logic [2*(1<<BA_W)-1:0]        bank_state_o,
    output logic [3:0]                    viol_code_o,
    output logic [NUM_CODES-1:0]          viol_sticky_o
);

    localparam int NUM_BANKS = 1 << BA_W;
    localparam int LIM = max2(max2(max2(T_RC, T_RAS), max2(T_RP, T_RCD)),
                              max2(max2(BURST_LEN / 2 + T_WR, T_RRD), max2(T_MRD, BURST_LEN)));
    localparam int CNT_W = $clog2(LIM + 1);

    cmd_e                  cmd;
    bank_st_e              bank_st   [NUM_BANKS];
    logic [NUM_CODES-1:0]  bank_req  [NUM_BANKS];
    logic [NUM_CODES-1:0]  glob_req;
    logic [NUM_CODES-1:0]  req_all;
    logic                  any_busy;
    logic [3:0]            code;
    report_t               rep_d, rep_q;

    ddrchk_decode u_decode (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        logic sel;
        assign sel = (ba == BA_W'(i)) || (cmd == CMD_PRE && a10);

        ddrchk_bank #(
            .T_RCD     (T_RCD),
            .T_RP      (T_RP),
            .T_RAS     (T_RAS),
            .T_RC      (T_RC),
            .T_WR      (T_WR),
            .BURST_LEN (BURST_LEN),
            .LIM       (LIM),
            .CNT_W     (CNT_W)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .cmd   (cmd),
            .sel   (sel),
            .a10   (a10),
            .st_o  (bank_st[i]),
            .req_o (bank_req[i])
        );

        assign bank_state_o[2*i +: 2] = bank_st[i];
    end

    ddrchk_global #(
        .T_RRD (T_RRD),
        .T_MRD (T_MRD),
        .BA_W  (BA_W),
        .LIM   (LIM),
        .CNT_W (CNT_W)
    ) u_global (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .ba       (ba),
        .any_busy (any_busy),
        .req_o    (glob_req)
    );

    always_comb begin
        any_busy = 1'b0;
        req_all  = glob_req;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (bank_st[i] != BK_IDLE) any_busy = 1'b1;
            req_all = req_all | bank_req[i];
        end
    end

    // lowest-numbered rule wins
    always_comb begin
        code = 4'd0;
        for (int k = NUM_CODES - 1; k >= 1; k--) begin
            if (req_all[k]) code = 4'(k);
        end
    end

    always_comb begin
        rep_d      = rep_q;
        rep_d.cmd  = cmd;
        rep_d.code = code;
        if (code != 4'd0) rep_d.sticky[code] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rep_q <= '0;
        end else begin
            rep_q <= rep_d;
        end
    end

    assign cmd_o         = rep_q.cmd;
    assign viol_code_o   = rep_q.code;
    assign viol_sticky_o = rep_q.sticky;

endmodule

// File: rtl/ddr_cmd_checker_props.sv
module ddr_cmd_checker_props #(
    parameter int BA_W      = 2,
    parameter int NCODE     = 12
)(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cs_n,
    input logic                   ras_n,
    input logic                   cas_n,
    input logic                   we_n,
    input logic [BA_W-1:0]        ba,
    input logic                   a10,
    input logic [3:0]             cmd_o,
    input logic [2*(1<<BA_W)-1:0] bank_state_o,
    input logic [3:0]             viol_code_o,
    input logic [NCODE-1:0]       viol_sticky_o
);

    localparam int NB = 1 << BA_W;

    logic is_nop, is_rdwr, is_act, is_pre;
    logic [1:0] sel_st;
    assign is_nop  = !cs_n && ras_n && cas_n && we_n;
    assign is_rdwr = !cs_n && ras_n && !cas_n;
    assign is_act  = !cs_n && !ras_n && cas_n && we_n;
    assign is_pre  = !cs_n && !ras_n && cas_n && !we_n;
    assign sel_st  = bank_state_o[2*ba +: 2];

    p_deselect_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> cmd_o == 4'd8);

    p_rdwr_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rdwr && sel_st == 2'd0) |=> (viol_code_o == 4'd3 || viol_code_o == 4'd2));

    p_act_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act && sel_st == 2'd1) |=> (viol_code_o == 4'd5 || viol_code_o == 4'd2));

    p_nop_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (is_nop || cs_n) |=> viol_code_o == 4'd0);

    p_code_in_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_code_o != 4'd0) |-> viol_sticky_o[viol_code_o]);

    p_sticky_keeps_r13: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((viol_sticky_o & $past(viol_sticky_o)) == $past(viol_sticky_o)));

    p_sticky_bit0_r13: assert property (@(posedge clk) disable iff (!rst_n)
        viol_sticky_o[0] == 1'b0);

    for (genvar i = 0; i < NB; i++) begin : g_bk
        p_state_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
            bank_state_o[2*i +: 2] != 2'd3);

        p_pre_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (is_pre && a10) |=> bank_state_o[2*i +: 2] != 2'd1);
    end

endmodule

bind ddr_cmd_checker ddr_cmd_checker_props #(.BA_W(BA_W), .NCODE(12)) u_props (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_n          (cs_n),
    .ras_n         (ras_n),
    .cas_n         (cas_n),
    .we_n          (we_n),
    .ba            (ba),
    .a10           (a10),
    .cmd_o         (cmd_o),
    .bank_state_o  (bank_state_o),
    .viol_code_o   (viol_code_o),
    .viol_sticky_o (viol_sticky_o)
);

// File: tb/ddr_cmd_checker_tb_top.sv
module ddr_cmd_checker_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BL    = 4;
    localparam int T_RCD = 3;
    localparam int T_RP  = 3;
    localparam int T_RRD = 2;
    localparam int T_RC  = 9;
    localparam int T_RAS = 6;
    localparam int T_WR  = 2;
    localparam int T_MRD = 2;

    localparam int C_NOP = 0, C_MRS = 1, C_REF = 2, C_ACT = 3, C_RD = 4,
                   C_WR = 5, C_BST = 6, C_PRE = 7, C_DES = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = 2'd0;
    logic        a10 = 1'b0;
    logic [3:0]  cmd_o;
    logic [7:0]  bank_state_o;
    logic [3:0]  viol_code_o;
    logic [11:0] viol_sticky_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr_cmd_checker dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_n          (cs_n),
        .ras_n         (ras_n),
        .cas_n         (cas_n),
        .we_n          (we_n),
        .ba            (ba),
        .a10           (a10),
        .cmd_o         (cmd_o),
        .bank_state_o  (bank_state_o),
        .viol_code_o   (viol_code_o),
        .viol_sticky_o (viol_sticky_o)
    );

    // ---------------- reference model (timestamps) ----------------
    int m_st [4];
    int m_act_t [4], m_pre_t [4], m_wr_t [4], m_ape [4];
    int m_mrs_t, m_any_act_t, m_last_b, t;
    logic [11:0] m_sticky;
    int m_cmd;
    int m_code;

    task automatic model_reset();
        for (int b = 0; b < 4; b++) begin
            m_st[b] = 0; m_act_t[b] = -100; m_pre_t[b] = -100;
            m_wr_t[b] = -100; m_ape[b] = -100;
        end
        m_mrs_t = -100; m_any_act_t = -100; m_last_b = 0;
        m_sticky = '0; t = 0; m_cmd = 0; m_code = 0;
    endtask

    task automatic settle(input int tt);
        for (int b = 0; b < 4; b++)
            if (m_st[b] == 2 && tt > m_ape[b]) begin
                m_st[b] = 0; m_pre_t[b] = m_ape[b];
            end
    endtask

    function automatic int pick(input int best, input int k);
        return (best == 0 || k < best) ? k : best;
    endfunction

    task automatic model_step(input int c, input int b, input bit a);
        int best = 0;
        if (c != C_NOP && c != C_DES && t - m_mrs_t < T_MRD) best = pick(best, 2);
        case (c)
            C_MRS: begin
                for (int i = 0; i < 4; i++) if (m_st[i] != 0) best = pick(best, 1);
                m_mrs_t = t;
            end
            C_ACT: begin
                if (b != m_last_b && t - m_any_act_t < T_RRD) best = pick(best, 7);
                if (m_st[b] == 1) best = pick(best, 5);
                else if (m_st[b] == 2) best = pick(best, 8);
                else begin
                    if (t - m_act_t[b] < T_RC) best = pick(best, 6);
                    if (t - m_pre_t[b] < T_RP) best = pick(best, 8);
                end
                m_act_t[b] = t; m_any_act_t = t; m_last_b = b; m_st[b] = 1;
            end
            C_RD, C_WR: begin
                if (m_st[b] == 0) best = pick(best, 3);
                else if (m_st[b] == 2) best = pick(best, 11);
                else begin
                    if (t - m_act_t[b] < T_RCD) best = pick(best, 4);
                    if (c == C_WR) m_wr_t[b] = t;
                    if (a) begin m_st[b] = 2; m_ape[b] = t + BL/2; end
                end
            end
            C_PRE: begin
                for (int i = 0; i < 4; i++)
                    if ((a || i == b) && m_st[i] == 1) begin
                        if (t - m_act_t[i] < T_RAS) best = pick(best, 9);
                        if (t - m_wr_t[i] < BL/2 + T_WR) best = pick(best, 10);
                        m_st[i] = 0; m_pre_t[i] = t;
                    end
            end
            default: ;
        endcase
        if (best != 0) m_sticky[best] = 1'b1;
        m_code = best;
        m_cmd  = c;
    endtask

    function automatic string tag_of(input int code);
        case (code)
            1, 2: return "R12";
            3: return "R3";   4: return "R4";   5: return "R5";
            6: return "R6";   7: return "R7";   8: return "R8";
            9: return "R9";   10: return "R10"; 11: return "R11";
            default: return "R13";
        endcase
    endfunction

    task automatic check(input int act, input int exp, input string tag, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, t);
        end
    endtask

    function automatic logic [7:0] exp_states();
        logic [7:0] v;
        for (int b = 0; b < 4; b++) v[2*b +: 2] = 2'(m_st[b]);
        return v;
    endfunction

    task automatic drive(input int c, input int b, input bit a);
        logic [3:0] p;
        case (c)
            C_MRS: p = 4'b0000;  C_REF: p = 4'b0001;  C_ACT: p = 4'b0011;
            C_RD:  p = 4'b0101;  C_WR:  p = 4'b0100;  C_BST: p = 4'b0110;
            C_PRE: p = 4'b0010;  C_DES: p = 4'b1111;  default: p = 4'b0111;
        endcase
        {cs_n, ras_n, cas_n, we_n} = p;
        ba  = 2'(b);
        a10 = a;
    endtask

    // one command per cycle; exp < 0 skips the literal check
    task automatic issue(input int c, input int b, input bit a, input int exp, input string tag);
        drive(c, b, a);
        model_step(c, b, a);
        @(negedge clk);
        t++;
        settle(t);
        check(int'(cmd_o), m_cmd, "R1", "cmd_o");
        check(int'(bank_state_o), int'(exp_states()), "R2", "bank_state_o");
        check(int'(viol_code_o), m_code, tag_of(m_code), "viol_code_o");
        check(int'(viol_sticky_o), int'(m_sticky), "R13", "viol_sticky_o");
        if (exp >= 0) check(int'(viol_code_o), exp, tag, "directed code");
    endtask

    task automatic nops(input int n);
        for (int i = 0; i < n; i++) issue(C_NOP, 0, 1'b0, 0, "R13");
    endtask

    task automatic do_reset();
        drive(C_NOP, 0, 1'b0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    bit finished = 1'b0;

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed_unused;
        seed_unused = $urandom(32'd7311);
        do_reset();
        // R13 reset state
        check(int'(viol_code_o), 0, "R13", "reset code");
        check(int'(viol_sticky_o), 0, "R13", "reset sticky");
        check(int'(bank_state_o), 0, "R13", "reset states");
        check(int'(cmd_o), 0, "R13", "reset cmd");

        issue(C_RD,  1, 1'b0, 3, "R3");
        check(int'(bank_state_o[3:2]), 0, "R3", "idle bank untouched");
        issue(C_ACT, 0, 1'b0, 0, "R2");
        issue(C_ACT, 1, 1'b0, 7, "R7");
        issue(C_RD,  0, 1'b0, 4, "R4");
        issue(C_RD,  0, 1'b0, 0, "R4");
        issue(C_ACT, 0, 1'b0, 5, "R5");
        issue(C_PRE, 0, 1'b0, 9, "R9");
        issue(C_ACT, 0, 1'b0, 6, "R6");   // also too soon after close: lower code wins (R13)
        nops(10);
        issue(C_PRE, 0, 1'b0, 0, "R9");
        issue(C_ACT, 0, 1'b0, 8, "R8");
        nops(6);
        issue(C_WR,  1, 1'b0, 0, "R10");
        issue(C_PRE, 1, 1'b0, 10, "R10");
        nops(6);
        issue(C_WR,  0, 1'b1, 0, "R11");
        check(int'(bank_state_o[1:0]), 2, "R11", "closing state");
        issue(C_RD,  0, 1'b0, 11, "R11");
        issue(C_NOP, 0, 1'b0, 0, "R11");
        check(int'(bank_state_o[1:0]), 0, "R11", "closed after burst");
        issue(C_ACT, 0, 1'b0, 8, "R8");
        issue(C_NOP, 0, 1'b0, 0, "R7");
        issue(C_ACT, 2, 1'b0, 0, "R7");
        nops(10);
        issue(C_PRE, 3, 1'b1, 0, "R2");
        check(int'(bank_state_o), 0, "R2", "precharge all");
        issue(C_MRS, 0, 1'b0, 0, "R12");
        issue(C_REF, 0, 1'b0, 2, "R12");
        issue(C_NOP, 0, 1'b0, 0, "R12");
        issue(C_ACT, 3, 1'b0, 0, "R12");
        issue(C_MRS, 0, 1'b0, 1, "R12");
        check(int'(viol_sticky_o), 12'hFFE, "R13", "all codes sticky");

        do_reset();
        @(negedge clk);
        check(int'(viol_sticky_o), 0, "R13", "sticky cleared by reset");
        check(int'(bank_state_o), 0, "R13", "states cleared by reset");

        for (int n = 0; n < 4000; n++) begin
            int r, c, b;
            bit a;
            r = int'($urandom_range(99));
            if (r < 40)      c = C_NOP;
            else if (r < 55) c = C_ACT;
            else if (r < 67) c = C_RD;
            else if (r < 79) c = C_WR;
            else if (r < 91) c = C_PRE;
            else if (r < 94) c = C_MRS;
            else if (r < 97) c = C_REF;
            else if (r < 99) c = C_BST;
            else             c = C_DES;
            b = int'($urandom_range(3));
            a = (c == C_PRE) ? ($urandom_range(3) == 0) : ($urandom_range(9) < 3);
            issue(c, b, a, -1, "R13");
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule